// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Controller

This block moves a programmed number of bytes between one I/O peripheral and memory. It never holds the system bus for more than one byte. Each byte needs its own handshake. The peripheral raises its request, the controller raises a bus request to the CPU, and it waits for the CPU's hold acknowledge. It then runs one byte cycle with the acknowledge to the peripheral asserted, and hands the bus back at once. The CPU sees one stolen bus cycle for every byte moved.

Software programs three items through a small write port: a start address, a byte count and a control word. The control word holds the transfer direction and an arm bit. In peripheral-to-memory mode the byte cycle pulls the I/O read and memory write strobes low together. In memory-to-peripheral mode it pulls the memory read and I/O write strobes low together. After every byte the address goes up by one and the count goes down by one. When the count runs out, a terminal-count flag rises and further peripheral requests are ignored until the channel is armed again.

Top module: `cs_dma_ctrl`

## Requirements
- R1: While reset is held and straight after it, hrq_o, dack_o, addr_oe_o and tc_o are 0, all four strobes are 1 and mem_addr_o is 0.
- R2: When the channel is armed and idle and dreq_i is sampled high at a clock edge, hrq_o is 1 after that edge.
- R3: While hrq_o is 1 and hlda_i has not yet been sampled high, addr_oe_o stays 0 and all strobes stay 1, however long the grant takes.
- R4: The first edge that samples hlda_i high starts one byte cycle, which lasts one clock. During it, dack_o and addr_oe_o are 1. If control bit 0 is 1 (peripheral to memory), ior_n_o and memw_n_o are 0 and iow_n_o and memr_n_o are 1. If control bit 0 is 0 (memory to peripheral), memr_n_o and iow_n_o are 0 and ior_n_o and memw_n_o are 1.
- R5: After every byte cycle, hrq_o and addr_oe_o drop on the next clock. An N-byte transfer produces exactly N separate rising edges of hrq_o. A new request is only considered after hlda_i has been seen low.
- R6: The first byte cycle drives the programmed start address on mem_addr_o. Each later byte drives the previous address plus one, wrapping modulo 2^ADDR_W.
- R7: tc_o goes to 1 on the clock that ends the byte cycle in which the count reaches zero, and it is 0 before then. While tc_o is 1, dreq_i produces no hrq_o.
- R8: Arming with a count of 0 performs no transfer. hrq_o stays 0 whatever dreq_i does, and tc_o is 0.
- R9: Configuration writes (cfg_sel_i 0 = address, 1 = count, 2 = control; control bit 1 = arm) are ignored while the channel is armed.
- R10: Outside a byte cycle, addr_oe_o and dack_o are 0, mem_addr_o is 0 and all four strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 0 address, 1 count, 2 control |
| cfg_wdata_i | input | CFG_W | Write data (control: bit 0 direction, bit 1 arm) |
| dreq_i | input | 1 | Peripheral transfer request |
| dack_o | output | 1 | Peripheral acknowledge, high during the byte cycle |
| hrq_o | output | 1 | Bus request to the CPU |
| hlda_i | input | 1 | Bus grant from the CPU |
| mem_addr_o | output | ADDR_W | Memory address during the byte cycle |
| addr_oe_o | output | 1 | Output enable for address and strobes |
| ior_n_o | output | 1 | I/O read strobe, active low |
| iow_n_o | output | 1 | I/O write strobe, active low |
| memr_n_o | output | 1 | Memory read strobe, active low |
| memw_n_o | output | 1 | Memory write strobe, active low |
| tc_o | output | 1 | Terminal count reached |

## Verification
A three-byte peripheral-to-memory run with a slow grant shows whether the controller waits for the grant and whether it releases the bus after each byte: the bench counts one bus request per byte and checks the strobe pair. A two-byte memory-to-peripheral run that starts at the top address tells the other strobe pair apart and exercises the address wrap. A zero-count arm and requests held high after terminal count show that requests are ignored in both cases. A run whose address and count are rewritten while armed shows whether those writes are correctly dropped.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_REL  = 2'd3
  } seq_state_t;

  typedef enum logic {
    DIR_M2P = 1'b0,
    DIR_P2M = 1'b1
  } dma_dir_t;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int CTRL_DIR_BIT = 0;
  localparam int CTRL_ARM_BIT = 1;

  // Strobe vector order (active high inside the block): {ior, iow, memr, memw}
  typedef struct packed {
    logic ior;
    logic iow;
    logic memr;
    logic memw;
  } strobe_t;

  function automatic strobe_t strobe_pattern(input dma_dir_t dir);
    strobe_t s;
    s = '0;
    if (dir == DIR_P2M) begin
      s.ior  = 1'b1;
      s.memw = 1'b1;
    end else begin
      s.memr = 1'b1;
      s.iow  = 1'b1;
    end
    return s;
  endfunction

endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
  import cs_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              byte_done,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output dma_dir_t          dir_q,
  output logic              armed_q,
  output logic              tc_q
);

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic cfg_ok;
  logic last_byte;
  logic cnt_zero;

  assign cfg_ok    = cfg_we && !armed_q;
  assign last_byte = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
  assign cnt_zero  = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      dir_q   <= DIR_M2P;
      armed_q <= 1'b0;
      tc_q    <= 1'b0;
    end else if (byte_done) begin
      addr_q <= addr_step(addr_q);
      cnt_q  <= cnt_step(cnt_q);
      if (last_byte) begin
        armed_q <= 1'b0;
        tc_q    <= 1'b1;
      end
    end else if (cfg_ok) begin
      case (cfg_sel)
        SEL_ADDR:  addr_q <= cfg_wdata[ADDR_W-1:0];
        SEL_COUNT: cnt_q  <= cfg_wdata[CNT_W-1:0];
        SEL_CTRL: begin
          dir_q <= dma_dir_t'(cfg_wdata[CTRL_DIR_BIT]);
          if (cfg_wdata[CTRL_ARM_BIT]) begin
            armed_q <= !cnt_zero;
            tc_q    <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cs_dma_seq.sv
module cs_dma_seq
  import cs_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic dreq,
  input  logic hlda,
  output logic hrq,
  output logic own,
  output logic byte_done
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (armed && dreq) state_d = ST_REQ;
      ST_REQ:  if (hlda)          state_d = ST_XFER;
      ST_XFER:                    state_d = ST_REL;
      ST_REL:  if (!hlda)         state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign hrq       = (state_q == ST_REQ) || (state_q == ST_XFER);
  assign own       = (state_q == ST_XFER);
  assign byte_done = own;

endmodule

// File: rtl/cs_dma_busdrv.sv
module cs_dma_busdrv
  import cs_dma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              own,
  input  dma_dir_t          dir,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe,
  output logic              dack,
  output logic              ior_n,
  output logic              iow_n,
  output logic              memr_n,
  output logic              memw_n
);

  strobe_t act;

  always_comb begin
    act = own ? strobe_pattern(dir) : '0;
  end

  assign addr_o  = own ? addr : '0;
  assign addr_oe = own;
  assign dack    = own;
  assign ior_n   = ~act.ior;
  assign iow_n   = ~act.iow;
  assign memr_n  = ~act.memr;
  assign memw_n  = ~act.memw;

endmodule

// File: rtl/cs_dma_ctrl.sv
module cs_dma_ctrl
  import cs_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int CFG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              dreq_i,
  output logic              dack_o,
  output logic              hrq_o,
  input  logic              hlda_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              addr_oe_o,
  output logic              ior_n_o,
  output logic              iow_n_o,
  output logic              memr_n_o,
  output logic              memw_n_o,
  output logic              tc_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  dma_dir_t          dir_q;
  logic              armed_q;
  logic              own;
  logic              byte_done;

  cs_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we_i),
    .cfg_sel   (cfg_sel_i),
    .cfg_wdata (cfg_wdata_i),
    .byte_done (byte_done),
    .addr_q    (addr_q),
    .cnt_q     (cnt_q),
    .dir_q     (dir_q),
    .armed_q   (armed_q),
    .tc_q      (tc_o)
  );

  cs_dma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed_q),
    .dreq      (dreq_i),
    .hlda      (hlda_i),
    .hrq       (hrq_o),
    .own       (own),
    .byte_done (byte_done)
  );

  cs_dma_busdrv #(.ADDR_W(ADDR_W)) u_bus (
    .own     (own),
    .dir     (dir_q),
    .addr    (addr_q),
    .addr_o  (mem_addr_o),
    .addr_oe (addr_oe_o),
    .dack    (dack_o),
    .ior_n   (ior_n_o),
    .iow_n   (iow_n_o),
    .memr_n  (memr_n_o),
    .memw_n  (memw_n_o)
  );

endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk
  import cs_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dreq,
  input logic              hrq,
  input logic              hlda,
  input logic              dack,
  input logic              bus_oe,
  input logic              ior_n,
  input logic              iow_n,
  input logic              memr_n,
  input logic              memw_n,
  input logic              tc,
  input dma_dir_t          dir,
  input logic              byte_done,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  cnt
);

  a_r2_req_follows_dreq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hrq) |-> $past(dreq));

  a_r3_grant_before_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(hlda));

  a_r4_p2m_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && dir == DIR_P2M) |-> (!ior_n && !memw_n && iow_n && memr_n && dack));

  a_r4_m2p_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && dir == DIR_M2P) |-> (!memr_n && !iow_n && ior_n && memw_n && dack));

  a_r5_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |=> (!bus_oe && !hrq));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (addr == $past(addr) + 1'b1));

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (cnt == $past(cnt) - 1'b1));

  a_r7_tc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> !hrq);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (ior_n && iow_n && memr_n && memw_n && !dack));

endmodule

bind cs_dma_ctrl cs_dma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dreq      (dreq_i),
  .hrq       (hrq_o),
  .hlda      (hlda_i),
  .dack      (dack_o),
  .bus_oe    (addr_oe_o),
  .ior_n     (ior_n_o),
  .iow_n     (iow_n_o),
  .memr_n    (memr_n_o),
  .memw_n    (memw_n_o),
  .tc        (tc_o),
  .dir       (dir_q),
  .byte_done (byte_done),
  .addr      (addr_q),
  .cnt       (cnt_q)
);

// File: tb/cs_dma_ctrl_tb.sv
`timescale 1ns/1ps
module cs_dma_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        dreq = 1'b0;
  logic        hlda = 1'b0;
  logic        dack, hrq, addr_oe, ior_n, iow_n, memr_n, memw_n, tc;
  logic [15:0] mem_addr;

  int n_checks = 0;
  int n_fail   = 0;
  int hrq_rises = 0;
  logic hrq_prev = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cs_dma_ctrl #(.ADDR_W(16), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .dreq_i(dreq), .dack_o(dack), .hrq_o(hrq),
    .hlda_i(hlda), .mem_addr_o(mem_addr), .addr_oe_o(addr_oe),
    .ior_n_o(ior_n), .iow_n_o(iow_n), .memr_n_o(memr_n), .memw_n_o(memw_n),
    .tc_o(tc)
  );

  always @(negedge clk) begin
    if (hrq && !hrq_prev) hrq_rises++;
    hrq_prev = hrq;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // strobes packed as {ior_n, iow_n, memr_n, memw_n}
  function automatic logic [3:0] strobes();
    return {ior_n, iow_n, memr_n, memw_n};
  endfunction

  task automatic serve_byte(input logic [15:0] exp_addr, input bit p2m);
    logic [3:0] exp_s;
    exp_s = p2m ? 4'b0110 : 4'b1001;
    dreq = 1'b1;
    @(negedge clk);
    chk(hrq == 1'b1, "R2 hrq after dreq", hrq, 1);
    chk(addr_oe == 1'b0 && strobes() == 4'hF, "R3 no bus before grant", {addr_oe, strobes()}, 5'h0F);
    @(negedge clk);
    chk(addr_oe == 1'b0 && strobes() == 4'hF && hrq, "R3 still waiting for grant", {hrq, addr_oe, strobes()}, 6'h2F);
    hlda = 1'b1;
    @(negedge clk);
    chk(addr_oe && dack, "R4 byte cycle owns bus", {addr_oe, dack}, 2'b11);
    chk(strobes() == exp_s, "R4 strobe pair", strobes(), exp_s);
    chk(mem_addr == exp_addr, "R6 address", mem_addr, exp_addr);
    dreq = 1'b0;
    @(negedge clk);
    chk(!hrq && !addr_oe && !dack, "R5 bus released", {hrq, addr_oe, dack}, 0);
    chk(strobes() == 4'hF && mem_addr == 16'h0, "R10 strobes idle", {mem_addr, strobes()}, 20'h0000F);
    hlda = 1'b0;
    @(negedge clk);
  endtask

  task automatic hold_dreq_expect_quiet(input string req);
    bit seen;
    seen = 1'b0;
    dreq = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (hrq) seen = 1'b1;
    end
    dreq = 1'b0;
    chk(!seen, req, seen, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!hrq && !dack && !addr_oe && !tc, "R1 controls low in reset", {hrq, dack, addr_oe, tc}, 0);
    chk(strobes() == 4'hF && mem_addr == 16'h0, "R1 strobes high in reset", {mem_addr, strobes()}, 20'h0000F);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hrq && !addr_oe && strobes() == 4'hF && !tc, "R1 after reset", {hrq, addr_oe, strobes(), tc}, 7'h1E);
  endtask

  task automatic t_p2m();
    int r0;
    cfg_write(2'd0, 16'h1000);
    cfg_write(2'd1, 16'd3);
    cfg_write(2'd2, 16'h0003);
    r0 = hrq_rises;
    serve_byte(16'h1000, 1'b1);
    chk(tc == 1'b0, "R7 tc low mid transfer", tc, 0);
    serve_byte(16'h1001, 1'b1);
    chk(tc == 1'b0, "R7 tc low before last", tc, 0);
    serve_byte(16'h1002, 1'b1);
    chk(tc == 1'b1, "R7 tc after last byte", tc, 1);
    chk(hrq_rises - r0 == 3, "R5 one request per byte", hrq_rises - r0, 3);
    hold_dreq_expect_quiet("R7 dreq ignored after tc");
  endtask

  task automatic t_m2p_wrap();
    cfg_write(2'd0, 16'hFFFF);
    cfg_write(2'd1, 16'd2);
    cfg_write(2'd2, 16'h0002);
    chk(tc == 1'b0, "R7 arm clears tc", tc, 0);
    serve_byte(16'hFFFF, 1'b0);
    serve_byte(16'h0000, 1'b0);
    chk(tc == 1'b1, "R7 tc after m2p", tc, 1);
  endtask

  task automatic t_zero();
    cfg_write(2'd1, 16'd0);
    cfg_write(2'd2, 16'h0003);
    hold_dreq_expect_quiet("R8 zero count no request");
    chk(tc == 1'b0, "R8 tc low on zero count", tc, 0);
  endtask

  task automatic t_locked();
    cfg_write(2'd0, 16'h2000);
    cfg_write(2'd1, 16'd2);
    cfg_write(2'd2, 16'h0003);
    cfg_write(2'd0, 16'h3000);
    cfg_write(2'd1, 16'd9);
    cfg_write(2'd2, 16'h0000);
    serve_byte(16'h2000, 1'b1);
    serve_byte(16'h2001, 1'b1);
    chk(tc == 1'b1, "R9 count kept while armed", tc, 1);
  endtask

  initial begin
    t_reset();
    t_p2m();
    t_m2p_wrap();
    t_zero();
    t_locked();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule